// File: doc/BRIEF.md
# Multi-master I2C transaction sequencer

This block is the bit and byte sequencer of an I2C master that shares an open-drain bus with other masters. A host issues one command at a time: start, write a byte, read a byte (with the acknowledge value to return), or stop. The sequencer turns each command into bus conditions and bit cells. It pulls SDA and SCL low through drive-low enables, and it reads the wired bus levels back. A free-running strobe from a separate rate generator paces the bus. Each bit cell takes four strobes. The sequencer holds off while another device keeps SCL low, so it follows clock stretching and clock synchronization.

A start issued while the bus is already owned produces a repeated start, with no stop before it. While it shifts out a byte, the sequencer compares each released bit with the sampled bus level. If the bus reads low where this master released SDA, the master has lost arbitration. It then lets go of both lines at once and stays passive as a receiver, sending no stop. It raises a sticky lost flag that blocks all further commands until the host clears it.

Top module: `i2cs_master`

## Requirements
- R1: After reset, sda_pull, scl_pull, busy, bus_owned, arb_lost, rx_nack and rx_data are all 0.
- R2: A start command (cmd_op 0) from an idle bus makes SDA fall while SCL is high, then pulls SCL low. It pulses done, and afterwards bus_owned is 1 and scl_pull is 1.
- R3: A write command (cmd_op 1) sends cmd_data MSB first, one bit per SCL high pulse, and changes SDA only while SCL is low. It then releases SDA for a ninth bit and stores the level sampled there in rx_nack (0 = acknowledged, 1 = not acknowledged).
- R4: A read command (cmd_op 2) releases SDA for eight bits, samples each one while SCL is high, and stores them MSB first in rx_data. On the ninth bit it pulls SDA low when cmd_ack is 1 and releases it when cmd_ack is 0.
- R5: A stop command (cmd_op 3) makes SDA rise while SCL is high. It leaves both lines released and clears bus_owned. This also holds after a byte the slave acknowledged.
- R6: A start command while bus_owned is 1 produces a new start condition with no stop condition before it, and bus_owned stays 1.
- R7: If a bit this master sent as 1 is sampled as 0 while SCL is high, the master releases SDA and SCL. Busy and bus_owned drop, arb_lost becomes 1, and no stop condition appears.
- R8: arb_lost stays 1 until an arb_clr pulse. While it is 1, every command is ignored: busy stays 0 and neither line is pulled.
- R9: Commands that arrive while busy is 1 are ignored, and so are write, read and stop commands while bus_owned is 0.
- R10: When another device holds SCL low after this master releases it, the sequencer waits. It samples and ends the bit only after SCL is seen high, so each SCL high phase lasts at least four clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle bit-timing strobe; four strobes form one bit cell |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_data | input | BYTE_W | Byte to send on a write |
| cmd_ack | input | 1 | On a read: 1 returns an acknowledge, 0 a not-acknowledge |
| arb_clr | input | 1 | Clears the arbitration-lost flag |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_pull | output | 1 | Drive SDA low when 1, release when 0 |
| scl_pull | output | 1 | Drive SCL low when 1, release when 0 |
| rx_data | output | BYTE_W | Last byte received by a read |
| rx_nack | output | 1 | Ninth-bit level sampled after the last write |
| done | output | 1 | One-cycle pulse when a command completes |
| busy | output | 1 | A command is in progress |
| bus_owned | output | 1 | This master holds the bus between start and stop |
| arb_lost | output | 1 | Sticky arbitration-lost flag |

## Verification
Writes are swept over all 256 byte values, and the acknowledge given by the modelled slave alternates between them. This catches a wrong bit order, a dropped or repeated bit, and a swapped acknowledge sense. Reads are swept over all 256 values, and the returned acknowledge alternates. This shows that the master samples only what the slave drives, and that it returns the requested ninth bit. Further sequences cover a repeated start, a stop after an acknowledged byte, commands given while not owning the bus or while busy, and slave clock stretching, which tells a bit engine that waits for SCL from one that runs blind on the strobe. A second model pulls SDA low during a released bit. This shows the silent release, the sticky flag, and that commands are blocked until the flag is cleared.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
// Package: shared command and bit-cell codes for the I2C sequencer.
// Assumes: command codes are fixed by the host-facing cmd_op encoding.
package i2cs_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } i2cs_op_e;

    typedef enum logic [1:0] {
        BK_START = 2'd0,
        BK_DATA  = 2'd1,
        BK_STOP  = 2'd2
    } i2cs_bit_e;

endpackage

// File: rtl/i2cs_bit_engine.sv
`timescale 1ns/1ps
// Module: i2cs_bit_engine
// Runs one bus cell (start condition, stop condition or data bit) in four
// strobe-paced phases: set SDA, release SCL, sample with SCL high, end.
// Assumes: go arrives only while idle; sda_in/scl_in are already
// synchronised; lines are open-drain, so only low enables are produced.
module i2cs_bit_engine
    import i2cs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      go,
    input  i2cs_bit_e kind,
    input  logic      tx_bit,
    input  logic      chk_arb,
    input  logic      sda_in,
    input  logic      scl_in,
    output logic      sda_pull,
    output logic      scl_pull,
    output logic      done,
    output logic      lost,
    output logic      sample
);

    logic      active;
    logic [1:0] phase;
    i2cs_bit_e kind_q;
    logic      bit_q;
    logic      chk_q;

    // Phase sequencer: applies the line action of each phase on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            phase    <= 2'd0;
            kind_q   <= BK_START;
            bit_q    <= 1'b1;
            chk_q    <= 1'b0;
            sda_pull <= 1'b0;
            scl_pull <= 1'b0;
            done     <= 1'b0;
            lost     <= 1'b0;
            sample   <= 1'b0;
        end else begin
            done <= 1'b0;
            lost <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    phase  <= 2'd0;
                    kind_q <= kind;
                    bit_q  <= tx_bit;
                    chk_q  <= chk_arb;
                end
            end else if (tick) begin
                case (phase)
                    2'd0: begin
                        // SCL is low (or idle high before a first start)
                        if (kind_q == BK_DATA) begin
                            sda_pull <= ~bit_q;
                        end else begin
                            sda_pull <= (kind_q == BK_STOP);
                        end
                        phase <= 2'd1;
                    end
                    2'd1: begin
                        scl_pull <= 1'b0;
                        phase    <= 2'd2;
                    end
                    2'd2: begin
                        // wait here while another device stretches SCL
                        if (scl_in) begin
                            sample <= sda_in;
                            if (kind_q == BK_DATA && chk_q && bit_q && !sda_in) begin
                                lost     <= 1'b1;
                                active   <= 1'b0;
                                sda_pull <= 1'b0;
                                scl_pull <= 1'b0;
                            end else begin
                                if (kind_q == BK_START) begin
                                    sda_pull <= 1'b1;
                                end else if (kind_q == BK_STOP) begin
                                    sda_pull <= 1'b0;
                                end
                                phase <= 2'd3;
                            end
                        end
                    end
                    default: begin
                        if (kind_q != BK_STOP) begin
                            scl_pull <= 1'b1;
                        end
                        done   <= 1'b1;
                        active <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cs_byte_ctrl.sv
`timescale 1ns/1ps
// Module: i2cs_byte_ctrl
// Accepts host commands, breaks bytes into bit cells for the bit engine,
// gathers received bits and the ninth-bit response, and keeps the bus
// ownership and sticky arbitration-lost state.
// Assumes: BYTE_W >= 2; the bit engine is idle whenever go is raised.
module i2cs_byte_ctrl
    import i2cs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              cmd_ack,
    input  logic              arb_clr,
    input  logic              eng_done,
    input  logic              eng_lost,
    input  logic              eng_sample,
    output logic              eng_go,
    output i2cs_bit_e         eng_kind,
    output logic              eng_bit,
    output logic              eng_chk,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_nack,
    output logic              done,
    output logic              busy,
    output logic              bus_owned,
    output logic              arb_lost
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);

    i2cs_op_e          op_q;
    i2cs_op_e          op_in;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              ack_q;
    logic              accept;

    // Command filter: one command at a time, start needed to own the bus.
    always_comb begin
        op_in  = i2cs_op_e'(cmd_op);
        accept = cmd_valid && !busy && !arb_lost &&
                 (op_in == OP_START || bus_owned);
    end

    // Command and byte sequencing, ownership and arbitration state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_START;
            shreg     <= '0;
            cnt       <= '0;
            ack_q     <= 1'b0;
            eng_go    <= 1'b0;
            eng_kind  <= BK_START;
            eng_bit   <= 1'b1;
            eng_chk   <= 1'b0;
            rx_data   <= '0;
            rx_nack   <= 1'b0;
            done      <= 1'b0;
            busy      <= 1'b0;
            bus_owned <= 1'b0;
            arb_lost  <= 1'b0;
        end else begin
            eng_go <= 1'b0;
            done   <= 1'b0;
            if (arb_clr) begin
                arb_lost <= 1'b0;
            end
            if (eng_lost) begin
                arb_lost  <= 1'b1;
                busy      <= 1'b0;
                bus_owned <= 1'b0;
            end else if (accept) begin
                busy   <= 1'b1;
                op_q   <= op_in;
                eng_go <= 1'b1;
                cnt    <= '0;
                ack_q  <= cmd_ack;
                case (op_in)
                    OP_START: eng_kind <= BK_START;
                    OP_STOP:  eng_kind <= BK_STOP;
                    OP_WRITE: begin
                        eng_kind <= BK_DATA;
                        eng_bit  <= cmd_data[BYTE_W-1];
                        eng_chk  <= 1'b1;
                        shreg    <= cmd_data;
                    end
                    default: begin
                        eng_kind <= BK_DATA;
                        eng_bit  <= 1'b1;
                        eng_chk  <= 1'b0;
                        shreg    <= '0;
                    end
                endcase
            end else if (busy && eng_done) begin
                case (op_q)
                    OP_START: begin
                        bus_owned <= 1'b1;
                        busy      <= 1'b0;
                        done      <= 1'b1;
                    end
                    OP_STOP: begin
                        bus_owned <= 1'b0;
                        busy      <= 1'b0;
                        done      <= 1'b1;
                    end
                    default: begin
                        if (cnt < ACK_SLOT) begin
                            shreg  <= {shreg[BYTE_W-2:0], eng_sample};
                            cnt    <= cnt + 1'b1;
                            eng_go <= 1'b1;
                            if (cnt == LAST_DATA) begin
                                eng_bit <= (op_q == OP_READ) ? ~ack_q : 1'b1;
                                eng_chk <= 1'b0;
                            end else begin
                                eng_bit <= (op_q == OP_WRITE) ? shreg[BYTE_W-2] : 1'b1;
                            end
                        end else begin
                            if (op_q == OP_READ) begin
                                rx_data <= shreg;
                            end else begin
                                rx_nack <= eng_sample;
                            end
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cs_master.sv
`timescale 1ns/1ps
// Module: i2cs_master (top)
// Multi-master I2C sequencer: a byte controller feeding a four-phase bit
// engine that drives SDA/SCL through low enables and watches arbitration.
// Assumes: tick comes from an external rate generator; bus levels are
// sampled and synchronised outside this block.
module i2cs_master
    import i2cs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              cmd_ack,
    input  logic              arb_clr,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_nack,
    output logic              done,
    output logic              busy,
    output logic              bus_owned,
    output logic              arb_lost
);

    logic      eng_go;
    i2cs_bit_e eng_kind;
    logic      eng_bit;
    logic      eng_chk;
    logic      eng_done;
    logic      eng_lost;
    logic      eng_sample;

    i2cs_byte_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_data   (cmd_data),
        .cmd_ack    (cmd_ack),
        .arb_clr    (arb_clr),
        .eng_done   (eng_done),
        .eng_lost   (eng_lost),
        .eng_sample (eng_sample),
        .eng_go     (eng_go),
        .eng_kind   (eng_kind),
        .eng_bit    (eng_bit),
        .eng_chk    (eng_chk),
        .rx_data    (rx_data),
        .rx_nack    (rx_nack),
        .done       (done),
        .busy       (busy),
        .bus_owned  (bus_owned),
        .arb_lost   (arb_lost)
    );

    i2cs_bit_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .go       (eng_go),
        .kind     (eng_kind),
        .tx_bit   (eng_bit),
        .chk_arb  (eng_chk),
        .sda_in   (sda_in),
        .scl_in   (scl_in),
        .sda_pull (sda_pull),
        .scl_pull (scl_pull),
        .done     (eng_done),
        .lost     (eng_lost),
        .sample   (eng_sample)
    );

endmodule

// File: rtl/i2cs_master_chk.sv
`timescale 1ns/1ps
// Module: i2cs_master_chk
// Property checker for i2cs_master, attached by the bind below.
// Assumes: synchronous active-low reset on rst_n.
module i2cs_master_chk
    import i2cs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       arb_clr,
    input logic       scl_in,
    input logic       sda_pull,
    input logic       scl_pull,
    input logic       busy,
    input logic       bus_owned,
    input logic       arb_lost,
    input logic       eng_lost,
    input i2cs_bit_e  eng_kind
);

    // R2: an accepted start makes the block busy
    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !arb_lost && cmd_op == 2'd0) |=> busy);

    // R3: SDA moves with SCL high only while forming start or stop
    assert_sda_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && $past(scl_in) && scl_in) |-> (eng_kind != BK_DATA));

    // R7: a lost bit ends in the passive state with the flag set
    assert_lost_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_lost |=> (arb_lost && !busy && !bus_owned));

    // R8: while lost, neither line is pulled
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (!sda_pull && !scl_pull));

    // R8: the flag holds until cleared
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !arb_clr) |=> arb_lost);

    // R8: commands are ignored while the flag is set
    assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !busy && cmd_valid) |=> !busy);

    // R9: only a start is taken while the bus is not owned
    assert_unowned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_owned && !busy && cmd_valid && cmd_op != 2'd0) |=> !busy);

endmodule

bind i2cs_master i2cs_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .arb_clr   (arb_clr),
    .scl_in    (scl_in),
    .sda_pull  (sda_pull),
    .scl_pull  (scl_pull),
    .busy      (busy),
    .bus_owned (bus_owned),
    .arb_lost  (arb_lost),
    .eng_lost  (eng_lost),
    .eng_kind  (eng_kind)
);

// File: tb/i2cs_master_bench.sv
`timescale 1ns/1ps
// Bench: drives i2cs_master over a modelled open-drain bus with a slave
// that acknowledges or sends bytes, can stretch SCL, and can act as a
// competing master pulling SDA low on a chosen bit.
module i2cs_master_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic [1:0] tdiv;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       cmd_ack = 1'b0;
    logic       arb_clr = 1'b0;
    logic       sda_pull, scl_pull, done, busy, bus_owned, arb_lost, rx_nack;
    logic [7:0] rx_data;
    logic       sda_bus, scl_bus;

    // slave / competitor model controls
    logic       mode_tx = 1'b0;
    logic [7:0] tx_byte = 8'd0;
    logic       ack_en = 1'b0;
    logic       interf = 1'b0;
    logic [3:0] interf_bit = 4'd0;
    int         stretch_len = 0;

    // monitor state
    logic       prev_sda, prev_scl, seen_rise, slv_act;
    logic [3:0] bitcnt;
    logic [7:0] mon_byte;
    logic       mon_ack;
    int         n_start, n_stop, hcnt, min_high, str_cnt;
    logic       slv_sda, slv_scl;
    logic [7:0] tsh;

    int n_checks = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    // strobe every fourth cycle
    always @(posedge clk) begin
        if (!rst_n) tdiv <= 2'd0;
        else        tdiv <= tdiv + 2'd1;
    end
    assign tick = (tdiv == 2'd3);

    assign sda_bus = !(sda_pull | slv_sda);
    assign scl_bus = !(scl_pull | slv_scl);

    always_comb begin
        tsh     = tx_byte << bitcnt;
        slv_sda = slv_act && ((mode_tx && bitcnt < 4'd8 && !tsh[7]) ||
                              (!mode_tx && bitcnt == 4'd8 && ack_en) ||
                              (interf && bitcnt == interf_bit));
        slv_scl = (str_cnt != 0);
    end

    // bus monitor and slave bit counter
    always @(posedge clk) begin
        if (!rst_n) begin
            prev_sda <= 1'b1; prev_scl <= 1'b1; seen_rise <= 1'b0; slv_act <= 1'b0;
            bitcnt <= 4'd0; mon_byte <= 8'd0; mon_ack <= 1'b1;
            n_start <= 0; n_stop <= 0; hcnt <= 0; min_high <= 1000; str_cnt <= 0;
        end else begin
            prev_sda <= sda_bus;
            prev_scl <= scl_bus;
            if (scl_bus) hcnt <= hcnt + 1;
            if (str_cnt != 0) str_cnt <= str_cnt - 1;
            if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
                n_start <= n_start + 1; bitcnt <= 4'd0; seen_rise <= 1'b0;
                slv_act <= 1'b1; mon_byte <= 8'd0;
            end else if (prev_scl && scl_bus && !prev_sda && sda_bus) begin
                n_stop <= n_stop + 1; slv_act <= 1'b0;
            end else if (!prev_scl && scl_bus) begin
                if (bitcnt < 4'd8) mon_byte <= {mon_byte[6:0], sda_bus};
                else               mon_ack <= sda_bus;
                seen_rise <= 1'b1;
            end else if (prev_scl && !scl_bus) begin
                if (hcnt < min_high) min_high <= hcnt;
                hcnt <= 0;
                if (stretch_len != 0) str_cnt <= stretch_len;
                if (seen_rise) begin
                    bitcnt <= (bitcnt == 4'd8) ? 4'd0 : bitcnt + 4'd1;
                    seen_rise <= 1'b0;
                end
            end
        end
    end

    i2cs_master #(.BYTE_W(8)) u_i2cs_master (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_ack(cmd_ack),
        .arb_clr(arb_clr), .sda_in(sda_bus), .scl_in(scl_bus),
        .sda_pull(sda_pull), .scl_pull(scl_pull), .rx_data(rx_data),
        .rx_nack(rx_nack), .done(done), .busy(busy), .bus_owned(bus_owned),
        .arb_lost(arb_lost)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_cmd(input logic [1:0] op, input logic [7:0] d, input logic a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_ack = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (!done && t < 4000) begin
            @(negedge clk);
            t++;
        end
        if (!done) check_eq({tag, " done timeout"}, 0, 1);
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [7:0] d, input logic a, input string tag);
        while (busy) @(negedge clk);
        pulse_cmd(op, d, a);
        wait_done(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #975000;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int s0, p0, errs;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check_eq("R1 sda_pull", sda_pull, 0);
        check_eq("R1 scl_pull", scl_pull, 0);
        check_eq("R1 busy", busy, 0);
        check_eq("R1 bus_owned", bus_owned, 0);
        check_eq("R1 arb_lost", arb_lost, 0);
        check_eq("R1 rx_nack", rx_nack, 0);
        check_eq("R1 rx_data", rx_data, 0);

        // R2 start from idle
        do_cmd(2'd0, 8'd0, 1'b0, "R2");
        check_eq("R2 start seen", n_start, 1);
        check_eq("R2 bus_owned", bus_owned, 1);
        check_eq("R2 scl held low", scl_pull, 1);
        check_eq("R2 no stop", n_stop, 0);

        // R3 write sweep, alternating slave acknowledge
        errs = 0;
        for (int v = 0; v < 256; v++) begin
            mode_tx = 1'b0;
            ack_en = v[0];
            do_cmd(2'd1, 8'(v), 1'b0, "R3");
            if (mon_byte != 8'(v)) begin
                errs++;
                check_eq("R3 bus byte", mon_byte, v);
            end
            if (rx_nack != !ack_en) begin
                errs++;
                check_eq("R3 rx_nack", rx_nack, !ack_en);
            end
        end
        check_eq("R3 write sweep mismatches", errs, 0);
        check_eq("R3 no spurious start", n_start, 1);
        check_eq("R3 no spurious stop", n_stop, 0);

        // R6 repeated start
        mode_tx = 1'b0; ack_en = 1'b0;
        do_cmd(2'd0, 8'd0, 1'b0, "R6");
        check_eq("R6 second start", n_start, 2);
        check_eq("R6 no stop between", n_stop, 0);
        check_eq("R6 bus_owned", bus_owned, 1);

        // R4 read sweep, alternating returned acknowledge
        errs = 0;
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            mode_tx = 1'b1;
            tx_byte = 8'(v);
            do_cmd(2'd2, 8'd0, !v[0], "R4");
            if (rx_data != 8'(v)) begin
                errs++;
                check_eq("R4 rx_data", rx_data, v);
            end
            if (mon_ack != v[0]) begin
                errs++;
                check_eq("R4 ninth bit", mon_ack, v[0]);
            end
        end
        check_eq("R4 read sweep mismatches", errs, 0);
        check_eq("R4 no spurious stop", n_stop, 0);

        // R5 stop after an acknowledged byte
        @(negedge clk);
        mode_tx = 1'b0; ack_en = 1'b1;
        do_cmd(2'd1, 8'h3C, 1'b0, "R5");
        check_eq("R5 byte acked", rx_nack, 0);
        ack_en = 1'b0;
        do_cmd(2'd3, 8'd0, 1'b0, "R5");
        check_eq("R5 stop seen", n_stop, 1);
        check_eq("R5 bus_owned", bus_owned, 0);
        check_eq("R5 sda released", sda_pull, 0);
        check_eq("R5 scl released", scl_pull, 0);

        // R9 write while not owned is ignored
        s0 = n_start;
        pulse_cmd(2'd1, 8'h00, 1'b0);
        idle(60);
        check_eq("R9 unowned write busy", busy, 0);
        check_eq("R9 unowned write sda", sda_pull, 0);
        check_eq("R9 unowned write scl", scl_pull, 0);
        // R9 stop while busy is ignored
        p0 = n_stop;
        pulse_cmd(2'd0, 8'd0, 1'b0);
        pulse_cmd(2'd3, 8'd0, 1'b0);
        wait_done("R9");
        idle(60);
        check_eq("R9 busy stop ignored", n_stop, p0);
        check_eq("R9 still owned", bus_owned, 1);
        check_eq("R9 one start", n_start, s0 + 1);
        do_cmd(2'd3, 8'd0, 1'b0, "R9");

        // R10 slave clock stretching
        stretch_len = 20;
        ack_en = 1'b1;
        @(negedge clk);
        min_high = 1000;
        do_cmd(2'd0, 8'd0, 1'b0, "R10");
        do_cmd(2'd1, 8'h96, 1'b0, "R10");
        check_eq("R10 stretched byte", mon_byte, 8'h96);
        check_eq("R10 stretched ack", rx_nack, 0);
        check_eq("R10 high at least 4", (min_high >= 4) ? 1 : 0, 1);
        ack_en = 1'b0;
        do_cmd(2'd3, 8'd0, 1'b0, "R10");
        stretch_len = 0;
        idle(40);

        // R7 arbitration loss on bit index 2 of 0xA5 (a released bit)
        ack_en = 1'b1;
        do_cmd(2'd0, 8'd0, 1'b0, "R7");
        p0 = n_stop;
        interf_bit = 4'd2;
        interf = 1'b1;
        pulse_cmd(2'd1, 8'hA5, 1'b0);
        for (int t = 0; t < 2000 && !arb_lost; t++) @(negedge clk);
        check_eq("R7 arb_lost", arb_lost, 1);
        check_eq("R7 busy", busy, 0);
        check_eq("R7 bus_owned", bus_owned, 0);
        check_eq("R7 sda released", sda_pull, 0);
        check_eq("R7 scl released", scl_pull, 0);
        idle(40);
        check_eq("R7 no stop", n_stop, p0);

        // R8 commands ignored while flag set
        s0 = n_start;
        pulse_cmd(2'd0, 8'd0, 1'b0);
        idle(60);
        check_eq("R8 ignored busy", busy, 0);
        check_eq("R8 ignored sda", sda_pull, 0);
        check_eq("R8 ignored scl", scl_pull, 0);
        check_eq("R8 sticky", arb_lost, 1);
        check_eq("R8 no start", n_start, s0);
        interf = 1'b0;
        ack_en = 1'b0;
        idle(10);
        @(negedge clk); arb_clr = 1'b1;
        @(negedge clk); arb_clr = 1'b0;
        check_eq("R8 cleared", arb_lost, 0);
        do_cmd(2'd0, 8'd0, 1'b0, "R8");
        check_eq("R8 start after clear", bus_owned, 1);
        do_cmd(2'd3, 8'd0, 1'b0, "R8");
        check_eq("R8 released after stop", bus_owned, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule